// File: doc/BRIEF.md
# Circular Buffer Pointer Wrap Stage

This block sits behind the adder of a data address generator and keeps a pointer inside a circular buffer. It takes the address the adder has just produced (the candidate), the old pointer value, the sign of the modifier that was applied, and the class of addressing in use. It checks the candidate against the buffer's first and last addresses. If the candidate has crossed the boundary it was moving toward, the block folds it back by one buffer length. It then decides which address goes to memory and whether the pointer register gets rewritten.

The bounds and a global enable live in a small configuration register, loaded through a write strobe. An inhibit input marks accesses on the write path for which bit-reversed addressing has taken over, and it turns the fold off for those accesses only. The three results are registered, so they appear one clock after the inputs.

Top module: `modcorr_top`

## Requirements
- R1: During synchronous reset and after it, all three outputs are zero, and the configuration is cleared with the enable at 0, so no folding happens until the configuration is written.
- R2: A cycle with `cfg_we_i` high loads enable, start and end. An access presented in that same cycle still uses the old configuration. Each access's results appear on the outputs one clock after it is presented.
- R3: With `dir_neg_i`=0, the candidate becomes candidate − (end − start + 1) only when it is strictly greater than the end address. A candidate equal to the end passes unchanged.
- R4: With `dir_neg_i`=1, the candidate becomes candidate + (end − start + 1) only when it is strictly less than the start address. A candidate equal to the start passes unchanged.
- R5: A candidate that overshoots a boundary by several addresses (but by less than one buffer length) lands at the matching place inside the buffer.
- R6: Only the boundary that matches the modifier sign is checked. An incrementing candidate below the start passes unchanged, and so does a decrementing candidate above the end.
- R7: Mode encoding on `mode_i` is 0 plain indirect, 1 pre-modify, 2 post-modify, 3 register-plus-offset. `wb_en_o` is 1 only for modes 1 and 2.
- R8: In pre-modify, both `ea_o` and `wb_val_o` carry the folded candidate. In post-modify, `ea_o` carries the old pointer and `wb_val_o` carries the folded candidate.
- R9: In register-plus-offset mode, `ea_o` carries the folded candidate, while `wb_val_o` keeps the old pointer and `wb_en_o` is 0.
- R10: When `path_wr_i`=1 and `brev_inh_i`=1, no folding takes place. On the read path (`path_wr_i`=0), `brev_inh_i` has no effect.
- R11: With the configured enable at 0, every candidate passes unchanged.
- R12: In plain indirect mode, `ea_o` and `wb_val_o` both carry the old pointer, and `wb_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value to load |
| cfg_start_i | input | ADDR_W | Buffer first address to load |
| cfg_end_i | input | ADDR_W | Buffer last address to load |
| cand_i | input | ADDR_W | Candidate address after the modifier has been applied |
| ptr_old_i | input | ADDR_W | Pointer register value before the modifier |
| dir_neg_i | input | 1 | Modifier sign: 1 means decrementing |
| mode_i | input | 2 | Addressing class |
| path_wr_i | input | 1 | Access is on the write path |
| brev_inh_i | input | 1 | Bit-reversed addressing owns the write path |
| ea_o | output | ADDR_W | Address sent to memory (registered) |
| wb_en_o | output | 1 | Pointer write-back enable (registered) |
| wb_val_o | output | ADDR_W | Value for the pointer register (registered) |

## Verification
Two functions can fall in the same cycle. The first pair is a configuration write and an access: the bench raises the strobe while presenting an access that would fold under the new bounds, and it expects the unfolded result first and the folded result only when the access is repeated. The second pair is the inhibit and an out-of-range write access. The bench presents the same out-of-range candidate on the write path and on the read path, with the inhibit held high, and expects the fold to be missing only on the write path.

// File: rtl/modcorr_pkg.sv
package modcorr_pkg;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_PREMOD  = 2'd1,
        AM_POSTMOD = 2'd2,
        AM_OFFSET  = 2'd3
    } amode_e;

    function automatic logic am_writes_back(amode_e m);
        return (m == AM_PREMOD) || (m == AM_POSTMOD);
    endfunction

endpackage

// File: rtl/modcorr_cfg.sv
module modcorr_cfg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         en_d,
    input  logic [W-1:0] lo_d,
    input  logic [W-1:0] hi_d,
    output logic         en_q,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q
);
    typedef struct packed {
        logic         en;
        logic [W-1:0] lo;
        logic [W-1:0] hi;
    } cfg_t;

    cfg_t cfg_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= '0;
        end else if (we) begin
            cfg_r <= '{en: en_d, lo: lo_d, hi: hi_d};
        end
    end

    assign en_q = cfg_r.en;
    assign lo_q = cfg_r.lo;
    assign hi_q = cfg_r.hi;
endmodule

// File: rtl/modcorr_wrap.sv
module modcorr_wrap #(
    parameter int W = 16
) (
    input  logic         active,
    input  logic         dir_neg,
    input  logic [W-1:0] cand,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] fixed
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] span;
    logic         over_hi;
    logic         under_lo;

    always_comb begin
        span     = hi - lo + ONE;
        over_hi  = !dir_neg && (cand > hi);
        under_lo = dir_neg && (cand < lo);
        if (active && over_hi) begin
            fixed = cand - span;
        end else if (active && under_lo) begin
            fixed = cand + span;
        end else begin
            fixed = cand;
        end
    end
endmodule

// File: rtl/modcorr_sel.sv
module modcorr_sel
    import modcorr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  amode_e       mode,
    input  logic [W-1:0] ptr_old,
    input  logic [W-1:0] fixed,
    output logic [W-1:0] ea_q,
    output logic         wb_en_q,
    output logic [W-1:0] wb_val_q
);
    typedef struct packed {
        logic [W-1:0] ea;
        logic         wb_en;
        logic [W-1:0] wb_val;
    } res_t;

    res_t nxt, cur;

    always_comb begin
        nxt.wb_en = am_writes_back(mode);
        unique case (mode)
            AM_PREMOD:  nxt.ea = fixed;
            AM_OFFSET:  nxt.ea = fixed;
            default:    nxt.ea = ptr_old;
        endcase
        nxt.wb_val = nxt.wb_en ? fixed : ptr_old;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign ea_q     = cur.ea;
    assign wb_en_q  = cur.wb_en;
    assign wb_val_q = cur.wb_val;
endmodule

// File: rtl/modcorr_top.sv
module modcorr_top
    import modcorr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic              cfg_en_i,
    input  logic [ADDR_W-1:0] cfg_start_i,
    input  logic [ADDR_W-1:0] cfg_end_i,
    input  logic [ADDR_W-1:0] cand_i,
    input  logic [ADDR_W-1:0] ptr_old_i,
    input  logic              dir_neg_i,
    input  logic [1:0]        mode_i,
    input  logic              path_wr_i,
    input  logic              brev_inh_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_val_o
);
    logic              cfg_en_q;
    logic [ADDR_W-1:0] cfg_lo_q;
    logic [ADDR_W-1:0] cfg_hi_q;
    logic [ADDR_W-1:0] fixed;
    logic              wrap_active;

    modcorr_cfg #(.W(ADDR_W)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we_i),
        .en_d (cfg_en_i),
        .lo_d (cfg_start_i),
        .hi_d (cfg_end_i),
        .en_q (cfg_en_q),
        .lo_q (cfg_lo_q),
        .hi_q (cfg_hi_q)
    );

    assign wrap_active = cfg_en_q && !(path_wr_i && brev_inh_i);

    modcorr_wrap #(.W(ADDR_W)) u_wrap (
        .active  (wrap_active),
        .dir_neg (dir_neg_i),
        .cand    (cand_i),
        .lo      (cfg_lo_q),
        .hi      (cfg_hi_q),
        .fixed   (fixed)
    );

    modcorr_sel #(.W(ADDR_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .mode     (amode_e'(mode_i)),
        .ptr_old  (ptr_old_i),
        .fixed    (fixed),
        .ea_q     (ea_o),
        .wb_en_q  (wb_en_o),
        .wb_val_q (wb_val_o)
    );
endmodule

// File: rtl/modcorr_chk.sv
module modcorr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cand,
    input logic [W-1:0] ptr_old,
    input logic         dir_neg,
    input logic [1:0]   mode,
    input logic         path_wr,
    input logic         brev_inh,
    input logic         cfg_en,
    input logic [W-1:0] cfg_hi,
    input logic [W-1:0] ea,
    input logic         wb_en,
    input logic [W-1:0] wb_val
);
    assert_wb_when_modify_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 || mode == 2'd2) |=> wb_en);

    assert_no_wb_otherwise_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 || mode == 2'd3) |=> !wb_en);

    assert_post_uses_old_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |=> (ea == $past(ptr_old)));

    assert_offset_keeps_ptr_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> (wb_val == $past(ptr_old)));

    assert_inhibit_write_R10: assert property (@(posedge clk) disable iff (rst)
        (path_wr && brev_inh && mode == 2'd1) |=> (ea == $past(cand)));

    assert_disabled_pass_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mode == 2'd1) |=> (ea == $past(cand)));

    assert_end_equal_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (!dir_neg && mode == 2'd1 && cand == cfg_hi) |=> (ea == $past(cand)));
endmodule

bind modcorr_top modcorr_chk #(.W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cand     (cand_i),
    .ptr_old  (ptr_old_i),
    .dir_neg  (dir_neg_i),
    .mode     (mode_i),
    .path_wr  (path_wr_i),
    .brev_inh (brev_inh_i),
    .cfg_en   (cfg_en_q),
    .cfg_hi   (cfg_hi_q),
    .ea       (ea_o),
    .wb_en    (wb_en_o),
    .wb_val   (wb_val_o)
);

// File: tb/tb_modcorr_top.sv
module tb_modcorr_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0, cfg_en = 1'b0;
    logic [W-1:0] cfg_start = '0, cfg_end = '0;
    logic [W-1:0] cand = '0, ptr_old = '0;
    logic         dir_neg = 1'b0, path_wr = 1'b0, brev_inh = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] ea, wb_val;
    logic         wb_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    modcorr_top #(.ADDR_W(W)) dut (
        .clk(clk), .rst(rst),
        .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
        .cfg_start_i(cfg_start), .cfg_end_i(cfg_end),
        .cand_i(cand), .ptr_old_i(ptr_old), .dir_neg_i(dir_neg),
        .mode_i(mode), .path_wr_i(path_wr), .brev_inh_i(brev_inh),
        .ea_o(ea), .wb_en_o(wb_en), .wb_val_o(wb_val)
    );

    typedef struct packed {
        logic         dir;
        logic [1:0]   md;
        logic         wr;
        logic         inh;
        logic [W-1:0] cnd;
        logic [W-1:0] ptr;
        logic [W-1:0] x_ea;
        logic         x_wb;
        logic [W-1:0] x_wbv;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 14;
    // buffer 0x1000..0x101F, length 0x20
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd1, 1'b0, 1'b0, 16'h1020, 16'h101E, 16'h1000, 1'b1, 16'h1000, 8'd3},  // R3 over end
        '{1'b0, 2'd1, 1'b0, 1'b0, 16'h101F, 16'h101D, 16'h101F, 1'b1, 16'h101F, 8'd3},  // R3 equal end
        '{1'b0, 2'd1, 1'b0, 1'b0, 16'h1025, 16'h1019, 16'h1005, 1'b1, 16'h1005, 8'd5},  // R5 big jump up
        '{1'b1, 2'd1, 1'b0, 1'b0, 16'h0FFE, 16'h1000, 16'h101E, 1'b1, 16'h101E, 8'd4},  // R4 under start
        '{1'b1, 2'd1, 1'b0, 1'b0, 16'h1000, 16'h1002, 16'h1000, 1'b1, 16'h1000, 8'd4},  // R4 equal start
        '{1'b1, 2'd1, 1'b0, 1'b0, 16'h0FF0, 16'h1008, 16'h1010, 1'b1, 16'h1010, 8'd5},  // R5 big jump down
        '{1'b0, 2'd3, 1'b0, 1'b0, 16'h0FF0, 16'h1004, 16'h0FF0, 1'b0, 16'h1004, 8'd6},  // R6 inc below start
        '{1'b1, 2'd3, 1'b0, 1'b0, 16'h1030, 16'h1004, 16'h1030, 1'b0, 16'h1004, 8'd6},  // R6 dec above end
        '{1'b0, 2'd2, 1'b0, 1'b0, 16'h1022, 16'h101E, 16'h101E, 1'b1, 16'h1002, 8'd8},  // R8 post-modify
        '{1'b0, 2'd3, 1'b0, 1'b0, 16'h1028, 16'h1010, 16'h1008, 1'b0, 16'h1010, 8'd9},  // R9 offset
        '{1'b0, 2'd1, 1'b1, 1'b1, 16'h1024, 16'h101E, 16'h1024, 1'b1, 16'h1024, 8'd10}, // R10 write inhibited
        '{1'b0, 2'd1, 1'b0, 1'b1, 16'h1024, 16'h101E, 16'h1004, 1'b1, 16'h1004, 8'd10}, // R10 read unaffected
        '{1'b0, 2'd2, 1'b1, 1'b0, 16'h1024, 16'h101E, 16'h101E, 1'b1, 16'h1004, 8'd7},  // R7 write no inhibit
        '{1'b0, 2'd0, 1'b0, 1'b0, 16'h1040, 16'h1040, 16'h1040, 1'b0, 16'h1040, 8'd12}  // R12 plain
    };

    task automatic chk(input int req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [W-1:0] lo, input logic [W-1:0] hi);
        @(negedge clk);
        cfg_we = 1'b1; cfg_en = en; cfg_start = lo; cfg_end = hi;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(1, "ea in reset", ea, '0);
        chk(1, "wb_en in reset", {15'd0, wb_en}, '0);
        chk(1, "wb_val in reset", wb_val, '0);
        rst = 1'b0;
        // R1: configuration cleared, so no folding after reset
        mode = 2'd1; dir_neg = 1'b0; cand = 16'h0005; ptr_old = 16'h0003;
        @(negedge clk);
        chk(1, "no fold after reset", ea, 16'h0005);

        write_cfg(1'b1, 16'h1000, 16'h101F);
        for (int i = 0; i < NV; i++) begin
            dir_neg = TBL[i].dir; mode = TBL[i].md; path_wr = TBL[i].wr;
            brev_inh = TBL[i].inh; cand = TBL[i].cnd; ptr_old = TBL[i].ptr;
            @(negedge clk);
            chk(TBL[i].req, $sformatf("vec %0d ea", i), ea, TBL[i].x_ea);
            chk(7, $sformatf("vec %0d wb_en", i), {15'd0, wb_en}, {15'd0, TBL[i].x_wb});
            chk(TBL[i].req, $sformatf("vec %0d wb_val", i), wb_val, TBL[i].x_wbv);
        end

        // R11: enable cleared, out-of-range candidate passes unchanged
        path_wr = 1'b0; brev_inh = 1'b0;
        write_cfg(1'b0, 16'h1000, 16'h101F);
        dir_neg = 1'b0; mode = 2'd1; cand = 16'h1020; ptr_old = 16'h101E;
        @(negedge clk);
        chk(11, "disabled ea", ea, 16'h1020);
        dir_neg = 1'b1; cand = 16'h0FF8;
        @(negedge clk);
        chk(11, "disabled dec ea", ea, 16'h0FF8);

        // R2: config write in the same cycle as an access uses the old config
        dir_neg = 1'b0; mode = 2'd1; cand = 16'h2008; ptr_old = 16'h2006;
        cfg_we = 1'b1; cfg_en = 1'b1; cfg_start = 16'h2000; cfg_end = 16'h2007;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(2, "same-cycle write uses old cfg", ea, 16'h2008);
        @(negedge clk);
        chk(2, "new cfg applies next access", ea, 16'h2000);
        chk(2, "new cfg write-back", wb_val, 16'h2000);

        // R1: reset mid-run clears outputs and configuration
        rst = 1'b1;
        @(negedge clk);
        chk(1, "ea after reassert", ea, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(1, "config cleared by reset", ea, 16'h2008);

        finish_run();
    end
endmodule